// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache

This block sits between a CPU instruction fetch port and a simple word-wide memory read port. It holds 4 KB of code as 1024 word slots, indexed by address bits [11:2]. Each slot keeps its own 24-bit tag, which is the low 24 bits of the byte address it was filled from. A slot whose tag and data are all ones is empty. The fetch side hands over an address and a peek flag. It receives a 32-bit opcode with a one-cycle valid pulse.

The top address byte decides whether a fetch may use the array. Only segments 0x00 and 0x80 are cacheable, and both map onto the same tags. Any other segment goes straight to memory as one read.

A cacheable miss that is not a peek fetches the whole aligned 16-byte line in ascending order. It writes all four words into the array and returns the word at the requested address. A peek that misses reads the single word and leaves the array alone. Reset or an invalidate pulse starts a sweep that clears one slot per cycle, and fetches are held off until the sweep ends.

Top module: `icache_fetch`

## Requirements
- R1: After reset, fetch_ready_o stays low for exactly 1024 cycles while every slot is cleared. An invalidate_i pulse likewise drops fetch_ready_o from the next cycle until a full sweep ends. After a sweep, every cacheable fetch misses.
- R2: Only fetches whose byte address bits [31:24] are 0x00 or 0x80 are cacheable. Any other top byte (for example 0x1F, 0xA0 or 0xBF) is served by one memory read at the requested word address. Such a fetch neither looks up nor allocates a slot.
- R3: A cacheable fetch hits when slot addr[11:2] holds a tag equal to {addr[23:2],2'b00}. fetch_valid_o then rises in the cycle after acceptance, with the stored word and no memory request.
- R4: A cacheable miss without peek reads four words, one request at a time, from byte addresses base, base+4, base+8 and base+12 in that order, where base is the address with bits [3:0] cleared. It writes each word and its tag into the matching slot.
- R5: A miss returns the memory word from the exact requested word address, and fetch_valid_o rises in the cycle after the last memory acknowledge.
- R6: A peek fetch (fetch_peek_i=1) that misses performs one memory read and leaves the array unchanged. A peek fetch that hits returns the stored word.
- R7: mem_req_o stays high with mem_addr_o stable until mem_ack_i is seen. mem_addr_o is always word aligned.
- R8: Each accepted fetch produces exactly one single-cycle fetch_valid_o pulse.
- R9: Address bits [1:0] are ignored. Because tags hold only address bits [23:0], a line filled through segment 0x00 hits from segment 0x80 and the reverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; starts a clearing sweep |
| invalidate_i | input | 1 | Single-cycle request to clear the whole array |
| fetch_req_i | input | 1 | Fetch request, taken when fetch_ready_o is high |
| fetch_addr_i | input | 32 | Fetch byte address |
| fetch_peek_i | input | 1 | Peek fetch: a miss does not allocate |
| fetch_ready_o | output | 1 | Block can accept a fetch this cycle |
| fetch_valid_o | output | 1 | One-cycle pulse, fetch_data_o holds the opcode |
| fetch_data_o | output | 32 | Returned opcode |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory byte address, word aligned |
| mem_ack_i | input | 1 | Memory read acknowledge, data valid |
| mem_data_i | input | 32 | Memory read data |

## Verification
Directed fetches first fill a line. The memory contents are then changed, so a hit, which still returns the old word, can be told apart from any read that reaches memory. Follow-up fetches probe the address pairs that separate the cases: segment 0x00 against segment 0x80 (aliasing), segment 0xA0 and 0x1F against 0x80 (no allocation), a peek miss followed by a normal fetch to the same address, same index with a different tag, and unaligned low bits. A seeded random mix then draws from a small address window in five segments with about a quarter peeks and occasional memory changes. Every fetch is compared against a bench model on the returned word, the number and order of memory reads, and the hit latency.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    ST_SWEEP  = 2'd0,
    ST_IDLE   = 2'd1,
    ST_FILL   = 2'd2,
    ST_SINGLE = 2'd3
  } icache_state_e;
endpackage

// File: rtl/icache_region.sv
module icache_region #(
  parameter int          SEG_W    = 8,
  parameter int          SEG_N    = 2,
  parameter logic [SEG_N*SEG_W-1:0] SEG_LIST = 16'h8000
) (
  input  logic [SEG_W-1:0] seg_i,
  output logic             cacheable_o
);
  logic [SEG_N-1:0] match;

  for (genvar g = 0; g < SEG_N; g++) begin : g_seg
    assign match[g] = (seg_i == SEG_LIST[g*SEG_W +: SEG_W]);
  end

  assign cacheable_o = |match;
endmodule

// File: rtl/icache_array.sv
module icache_array #(
  parameter int SLOTS  = 1024,
  parameter int TAG_W  = 24,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [TAG_W-1:0]  tag_mem  [SLOTS];
  logic [DATA_W-1:0] data_mem [SLOTS];

  // contents are defined by the controller's clearing sweep, not by reset
  always_ff @(posedge clk_i) begin
    if (we_i) begin
      tag_mem[wr_idx_i]  <= wr_tag_i;
      data_mem[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_tag_o  = tag_mem[rd_idx_i];
  assign rd_data_o = data_mem[rd_idx_i];
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SLOTS      = 1024,
  parameter int TAG_W      = 24,
  parameter int LINE_WORDS = 4,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int WA_W   = ADDR_W - 2,
  localparam int WSEL_W = $clog2(LINE_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              invalidate_i,
  input  logic              fetch_req_i,
  input  logic [WA_W-1:0]   fetch_wa_i,
  input  logic              fetch_peek_i,
  input  logic              cacheable_i,
  output logic              fetch_ready_o,
  output logic              fetch_valid_o,
  output logic [DATA_W-1:0] fetch_data_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              we_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [TAG_W-1:0]  wr_tag_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_data_i
);
  localparam logic [WSEL_W-1:0] LAST_W    = WSEL_W'(LINE_WORDS - 1);
  localparam logic [IDX_W-1:0]  LAST_SLOT = IDX_W'(SLOTS - 1);

  icache_state_e     st_q;
  logic [IDX_W-1:0]  sweep_q;
  logic              inv_pend_q;
  logic [WA_W-1:0]   addr_q;
  logic [WSEL_W-1:0] wsel_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  logic            accept, hit, sweep_start;
  logic [WA_W-1:0] mem_wa;

  assign fetch_ready_o = (st_q == ST_IDLE) && !inv_pend_q;
  assign accept        = fetch_req_i && fetch_ready_o;
  assign rd_idx_o      = fetch_wa_i[IDX_W-1:0];
  assign hit           = (rd_tag_i == {fetch_wa_i[TAG_W-3:0], 2'b00});
  assign sweep_start   = (st_q == ST_IDLE) && inv_pend_q;

  always_comb begin
    mem_wa = addr_q;
    if (st_q == ST_FILL) mem_wa = {addr_q[WA_W-1:WSEL_W], wsel_q};
  end

  assign mem_req_o  = (st_q == ST_FILL) || (st_q == ST_SINGLE);
  assign mem_addr_o = {mem_wa, 2'b00};

  always_comb begin
    we_o      = 1'b0;
    wr_idx_o  = mem_wa[IDX_W-1:0];
    wr_tag_o  = {mem_wa[TAG_W-3:0], 2'b00};
    wr_data_o = mem_data_i;
    if (st_q == ST_SWEEP) begin
      we_o      = 1'b1;
      wr_idx_o  = sweep_q;
      wr_tag_o  = '1;
      wr_data_o = '1;
    end else if (st_q == ST_FILL && mem_ack_i) begin
      we_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_SWEEP;
      sweep_q    <= '0;
      inv_pend_q <= 1'b0;
      addr_q     <= '0;
      wsel_q     <= '0;
      valid_q    <= 1'b0;
      data_q     <= '0;
    end else begin
      valid_q    <= 1'b0;
      inv_pend_q <= invalidate_i || (inv_pend_q && !sweep_start);
      unique case (st_q)
        ST_SWEEP: begin
          sweep_q <= sweep_q + 1'b1;
          if (sweep_q == LAST_SLOT) st_q <= ST_IDLE;
        end
        ST_IDLE: begin
          if (sweep_start) begin
            st_q    <= ST_SWEEP;
            sweep_q <= '0;
          end else if (accept) begin
            addr_q <= fetch_wa_i;
            wsel_q <= '0;
            if (cacheable_i && hit) begin
              valid_q <= 1'b1;
              data_q  <= rd_data_i;
            end else if (cacheable_i && !fetch_peek_i) begin
              st_q <= ST_FILL;
            end else begin
              st_q <= ST_SINGLE;
            end
          end
        end
        ST_FILL: begin
          if (mem_ack_i) begin
            if (wsel_q == addr_q[WSEL_W-1:0]) data_q <= mem_data_i;
            wsel_q <= wsel_q + 1'b1;
            if (wsel_q == LAST_W) begin
              valid_q <= 1'b1;
              st_q    <= ST_IDLE;
            end
          end
        end
        ST_SINGLE: begin
          if (mem_ack_i) begin
            data_q  <= mem_data_i;
            valid_q <= 1'b1;
            st_q    <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign fetch_valid_o = valid_q;
  assign fetch_data_o  = data_q;

  assert_inv_blocks_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalidate_i |=> !fetch_ready_o);
  assert_hit_next_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cacheable_i && hit) |=> (fetch_valid_o && !mem_req_o));
  assert_fill_ascends_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FILL && mem_ack_i && wsel_q != LAST_W) |=> (mem_addr_o == $past(mem_addr_o) + 4));
  assert_single_no_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SINGLE) |-> !we_o);
  assert_req_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
  assert_valid_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_o && !$past(fetch_ready_o)) |=> !fetch_valid_o);
endmodule

// File: rtl/icache_fetch.sv
module icache_fetch #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CACHE_BYTES = 4096,
  parameter int LINE_WORDS  = 4,
  parameter int TAG_W       = 24,
  parameter int SEG_N       = 2,
  parameter logic [SEG_N*8-1:0] SEG_LIST = 16'h8000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              invalidate_i,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              fetch_peek_i,
  output logic              fetch_ready_o,
  output logic              fetch_valid_o,
  output logic [DATA_W-1:0] fetch_data_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_data_i
);
  localparam int SLOTS = CACHE_BYTES / (DATA_W / 8);
  localparam int IDX_W = $clog2(SLOTS);

  logic              cacheable;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [TAG_W-1:0]  rd_tag, wr_tag;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              we;
  logic              unused_lo;

  assign unused_lo = ^fetch_addr_i[1:0];

  icache_region #(.SEG_W(8), .SEG_N(SEG_N), .SEG_LIST(SEG_LIST)) u_region (
    .seg_i       (fetch_addr_i[ADDR_W-1 -: 8]),
    .cacheable_o (cacheable)
  );

  icache_array #(.SLOTS(SLOTS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
    .clk_i     (clk_i),
    .rd_idx_i  (rd_idx),
    .rd_tag_o  (rd_tag),
    .rd_data_o (rd_data),
    .we_i      (we),
    .wr_idx_i  (wr_idx),
    .wr_tag_i  (wr_tag),
    .wr_data_i (wr_data)
  );

  icache_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOTS(SLOTS),
    .TAG_W(TAG_W), .LINE_WORDS(LINE_WORDS)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .invalidate_i  (invalidate_i),
    .fetch_req_i   (fetch_req_i),
    .fetch_wa_i    (fetch_addr_i[ADDR_W-1:2]),
    .fetch_peek_i  (fetch_peek_i),
    .cacheable_i   (cacheable),
    .fetch_ready_o (fetch_ready_o),
    .fetch_valid_o (fetch_valid_o),
    .fetch_data_o  (fetch_data_o),
    .rd_idx_o      (rd_idx),
    .rd_tag_i      (rd_tag),
    .rd_data_i     (rd_data),
    .we_o          (we),
    .wr_idx_o      (wr_idx),
    .wr_tag_o      (wr_tag),
    .wr_data_o     (wr_data),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .mem_ack_i     (mem_ack_i),
    .mem_data_i    (mem_data_i)
  );
endmodule

// File: tb/icache_fetch_bench.sv
module icache_fetch_bench;
  localparam int NSLOT = 1024;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        inv = 1'b0;
  logic        freq = 1'b0;
  logic [31:0] faddr = '0;
  logic        fpeek = 1'b0;
  logic        ready, valid, mreq;
  logic [31:0] fdata, maddr;
  logic        mack = 1'b0;
  logic [31:0] mdata = '0;

  int unsigned ver = 1;
  int          n_tests = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  int          rd_n = 0;
  logic [31:0] rd_log [8];
  logic [23:0] m_tag [NSLOT];
  logic [31:0] m_dat [NSLOT];

  always #2 clk = ~clk;

  icache_fetch u_icache_fetch (
    .clk_i(clk), .rst_ni(rst_ni), .invalidate_i(inv),
    .fetch_req_i(freq), .fetch_addr_i(faddr), .fetch_peek_i(fpeek),
    .fetch_ready_o(ready), .fetch_valid_o(valid), .fetch_data_o(fdata),
    .mem_req_o(mreq), .mem_addr_o(maddr), .mem_ack_i(mack), .mem_data_i(mdata)
  );

  function automatic logic [31:0] mem_word(logic [31:0] a, int unsigned v);
    return ({a[31:2], 2'b00} * 32'h9E37_79B1) ^ (v * 32'h0101_0101);
  endfunction

  function automatic bit is_cacheable(logic [31:0] a);
    return (a[31:24] == 8'h00) || (a[31:24] == 8'h80);
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NSLOT; i++) begin
      m_tag[i] = '1;
      m_dat[i] = '1;
    end
  endtask

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: random 0..2 cycle latency, one-cycle ack
  initial begin
    int dly = -1;
    forever begin
      @(negedge clk);
      if (mack) begin
        mack = 1'b0;
        dly = -1;
      end else if (mreq) begin
        if (dly < 0) dly = $urandom_range(2, 0);
        if (dly == 0) begin
          mack  = 1'b1;
          mdata = mem_word(maddr, ver);
          if (rd_n < 8) rd_log[rd_n] = maddr;
          rd_n++;
          dly = -1;
        end else dly--;
      end
    end
  end

  task automatic do_fetch(logic [31:0] a, bit pk, output logic [31:0] d, output int lat);
    @(negedge clk);
    rd_n  = 0;
    freq  = 1'b1;
    faddr = a;
    fpeek = pk;
    while (!ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    freq = 1'b0;
    lat  = 1;
    while (!valid) begin
      @(negedge clk);
      lat++;
    end
    d = fdata;
    @(negedge clk);
    chk(!valid, "R8", "valid pulse width", 32'(valid), 32'd0);
  endtask

  // compares one fetch with the bench model; tag names the requirement in focus
  task automatic fetch_check(logic [31:0] a, bit pk, string tag);
    logic [31:0] d, exp_d, base;
    logic [9:0]  idx;
    int          lat, exp_n;
    bit          hit, fill;
    idx   = a[11:2];
    base  = {a[31:4], 4'h0};
    hit   = is_cacheable(a) && (m_tag[idx] == {a[23:2], 2'b00});
    fill  = is_cacheable(a) && !hit && !pk;
    exp_d = hit ? m_dat[idx] : mem_word(a, ver);
    exp_n = hit ? 0 : (fill ? 4 : 1);
    do_fetch(a, pk, d, lat);
    chk(d == exp_d, tag, "returned word", d, exp_d);
    chk(rd_n == exp_n, tag, "memory read count", 32'(rd_n), 32'(exp_n));
    if (hit) chk(lat == 1, "R3", "hit latency", 32'(lat), 32'd1);
    if (fill && rd_n == 4) begin
      for (int k = 0; k < 4; k++)
        chk(rd_log[k] == base + 32'(4 * k), "R4", "fill address order", rd_log[k], base + 32'(4 * k));
    end
    if (!hit && !fill && rd_n == 1)
      chk(rd_log[0] == {a[31:2], 2'b00}, "R2", "single read address", rd_log[0], {a[31:2], 2'b00});
    if (fill) begin
      for (int k = 0; k < 4; k++) begin
        m_tag[base[11:2] + 10'(k)] = base[23:0] + 24'(4 * k);
        m_dat[base[11:2] + 10'(k)] = mem_word(base + 32'(4 * k), ver);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual cycles 200000 expected fewer");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int   cnt;
    logic [7:0] segs [5];
    void'($urandom(32'd4242));
    segs[0] = 8'h00; segs[1] = 8'h80; segs[2] = 8'hA0; segs[3] = 8'hBF; segs[4] = 8'h1F;
    model_clear();

    // reset state
    repeat (3) @(negedge clk);
    chk(!ready && !valid && !mreq, "R1", "outputs in reset", {29'd0, ready, valid, mreq}, 32'd0);
    rst_ni = 1'b1;
    cnt = 0;
    while (!ready) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == NSLOT, "R1", "sweep length after reset", 32'(cnt), 32'(NSLOT));

    fetch_check(32'h8000_0104, 1'b0, "R4");   // first fetch misses, fills line
    fetch_check(32'h8000_0100, 1'b0, "R3");   // hit
    ver = 2;                                  // memory changes, cache keeps old words
    fetch_check(32'h8000_0108, 1'b0, "R3");
    fetch_check(32'h0000_010C, 1'b0, "R9");   // alias segment hits
    fetch_check(32'hA000_010C, 1'b0, "R2");   // uncached returns new word
    fetch_check(32'h8000_010C, 1'b0, "R2");   // still stale hit
    fetch_check(32'hA000_0200, 1'b0, "R2");
    fetch_check(32'h8000_0200, 1'b0, "R2");   // uncached did not allocate: miss
    fetch_check(32'h1F00_0104, 1'b0, "R2");   // low segment, not cacheable
    fetch_check(32'h8000_0300, 1'b1, "R6");   // peek miss
    fetch_check(32'h8000_0300, 1'b0, "R6");   // still a miss: fill
    fetch_check(32'h8000_0304, 1'b1, "R6");   // peek hit
    fetch_check(32'h8000_1104, 1'b0, "R5");   // same index other tag: miss
    fetch_check(32'h8000_1107, 1'b0, "R9");   // low bits ignored: hit
    fetch_check(32'h8000_0104, 1'b0, "R5");   // evicted: miss with new word

    // invalidate pulse
    @(negedge clk);
    inv = 1'b1;
    @(negedge clk);
    inv = 1'b0;
    chk(!ready, "R1", "ready after invalidate", 32'(ready), 32'd0);
    cnt = 1;
    while (!ready) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt >= NSLOT, "R1", "sweep length after invalidate", 32'(cnt), 32'(NSLOT));
    model_clear();
    fetch_check(32'h8000_1104, 1'b0, "R1");   // must miss after sweep

    // seeded random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      a = {segs[$urandom_range(4, 0)], 12'h000, 1'($urandom_range(1, 0)), 11'h000}
          | {22'd0, 8'($urandom_range(255, 0)), 2'($urandom_range(3, 0))};
      if ($urandom_range(9, 0) == 0) ver++;
      fetch_check(a, ($urandom_range(3, 0) == 0), "R5");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule